// File: doc/BRIEF.md
# Speculative Cache Line Tag Tracker and Dependence Violation Detector

This block keeps the speculation tag state for the lines of one core's primary data cache while that core runs a speculative thread. Each line has one read flag and one written flag per word, a line-level modified flag and a line-level stale-on-commit flag. Local loads and stores update these flags. Stores from other cores are snooped from the shared write bus. A store from a thread that comes earlier in program order may break a read-after-write dependence, so the block checks it against the read and written flags. A store from a thread that comes later in program order cannot break a dependence for this core. It only marks the line so that the line is dropped when this thread commits.

The surrounding cache owns the tag and data arrays. It presents events as a decoded line index plus a word offset or a word mask. It acts on the block's two results: a sticky violation flag, which the thread control logic answers with a restart, and a one-cycle line invalidation mask, which it applies to the cache's valid bits. The mask comes from three sources: the line hit by an earlier writer, the lines to discard on restart, and the lines made stale by later writers, released on commit.

Top module: `spec_tag_tracker`

## Requirements
- R1: After reset, `violation` is 0 and `inv_mask` is all zeros.
- R2: A load with `ld_miss`=0 sets the read flag of word `ld_word` in line `ld_idx`. It does not mark the line modified.
- R3: A load with `ld_miss`=1 sets the read flag of the word and also marks the line modified.
- R4: A local store sets the written flag of word `st_word` in line `st_idx` and marks the line modified. A word that has been written locally never causes a violation, even if it was read earlier.
- R5: A snooped store with `snp_earlier`=1 sets bit `snp_idx` of `inv_mask` in the following cycle. It raises `violation` in the following cycle if, for some word with its bit set in `snp_mask` (bit w = word w), that word of the line has its read flag set and its written flag clear.
- R6: A snooped store with `snp_earlier`=0 invalidates nothing and never raises `violation`. It marks the line stale for commit.
- R7: Once raised, `violation` stays at 1 until a restart.
- R8: A `restart` pulse sets `inv_mask` to the set of modified lines in the following cycle, ORed with any earlier-writer line from the same cycle. It clears `violation` and all read, written and modified flags. The stale-for-commit marks are kept.
- R9: A `commit` pulse sets `inv_mask` to the set of stale-for-commit lines in the following cycle, ORed with any earlier-writer line from the same cycle. It clears all four kinds of flag.
- R10: `restart` takes precedence over `commit`. In a cycle with `restart` or `commit` high, local loads, local stores and later-writer snoops do not set any flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_valid | input | 1 | Local speculative load this cycle |
| ld_idx | input | $clog2(LINES) | Line of the load |
| ld_word | input | $clog2(WORDS) | Word offset of the load |
| ld_miss | input | 1 | Load missed and fills the line |
| st_valid | input | 1 | Local speculative store this cycle |
| st_idx | input | $clog2(LINES) | Line of the store |
| st_word | input | $clog2(WORDS) | Word offset of the store |
| snp_valid | input | 1 | Snooped store from another core that matches a resident line |
| snp_idx | input | $clog2(LINES) | Resident line matched by the snooped store |
| snp_mask | input | WORDS | Words written by the snooped store |
| snp_earlier | input | 1 | 1 if the writer comes earlier in program order, 0 if later |
| commit | input | 1 | Thread commits its speculative state |
| restart | input | 1 | Thread discards its speculative state |
| violation | output | 1 | Sticky read-after-write dependence violation |
| inv_mask | output | LINES | One-cycle mask of lines to invalidate |

## Verification
Both results are registered once. `inv_mask` and any new `violation` reflect the inputs of the cycle before, and they are computed from the flag state that existed before that cycle's own updates. The bench drives each cycle's inputs on the falling edge. It advances its behavioural model with those inputs and compares both outputs on the next falling edge, which is exactly one rising edge later. Flag effects that have no direct output, such as read, written and stale marks, are brought out by a later snoop, restart or commit and checked at the cycle after that command.

// File: rtl/spec_tag_tracker.sv
module spec_tag_tracker #(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  localparam int IW = $clog2(LINES),
  localparam int WW = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_valid,
  input  logic [IW-1:0]    ld_idx,
  input  logic [WW-1:0]    ld_word,
  input  logic             ld_miss,
  input  logic             st_valid,
  input  logic [IW-1:0]    st_idx,
  input  logic [WW-1:0]    st_word,
  input  logic             snp_valid,
  input  logic [IW-1:0]    snp_idx,
  input  logic [WORDS-1:0] snp_mask,
  input  logic             snp_earlier,
  input  logic             commit,
  input  logic             restart,
  output logic             violation,
  output logic [LINES-1:0] inv_mask
);

  logic [WORDS-1:0] rd_q [LINES];
  logic [WORDS-1:0] wr_q [LINES];
  logic [LINES-1:0] mod_q, stale_q, inv_q, snp_line;
  logic             viol_q, early, hazard, quiet;

  assign early    = snp_valid & snp_earlier;
  assign hazard   = early & |(snp_mask & rd_q[snp_idx] & ~wr_q[snp_idx]);
  assign snp_line = early ? (LINES'(1) << snp_idx) : '0;
  assign quiet    = ~restart & ~commit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      viol_q  <= 1'b0;
      inv_q   <= '0;
      mod_q   <= '0;
      stale_q <= '0;
      for (int i = 0; i < LINES; i++) begin
        rd_q[i] <= '0;
        wr_q[i] <= '0;
      end
    end else begin
      viol_q <= ~restart & (viol_q | hazard);
      if (restart)     inv_q <= mod_q | snp_line;
      else if (commit) inv_q <= stale_q | snp_line;
      else             inv_q <= snp_line;

      if (!quiet) begin
        mod_q <= '0;
        for (int i = 0; i < LINES; i++) begin
          rd_q[i] <= '0;
          wr_q[i] <= '0;
        end
        if (!restart) stale_q <= '0;
      end else begin
        if (ld_valid) begin
          rd_q[ld_idx][ld_word] <= 1'b1;
          if (ld_miss) mod_q[ld_idx] <= 1'b1;
        end
        if (st_valid) begin
          wr_q[st_idx][st_word] <= 1'b1;
          mod_q[st_idx]         <= 1'b1;
        end
        if (snp_valid && !snp_earlier) stale_q[snp_idx] <= 1'b1;
      end
    end
  end

  assign violation = viol_q;
  assign inv_mask  = inv_q;

endmodule

// File: rtl/spec_tag_tracker_chk.sv
module spec_tag_tracker_chk #(
  parameter int LINES = 16,
  parameter int WORDS = 4,
  localparam int IW = $clog2(LINES),
  localparam int WW = $clog2(WORDS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             snp_valid,
  input logic [IW-1:0]    snp_idx,
  input logic             snp_earlier,
  input logic             commit,
  input logic             restart,
  input logic             violation,
  input logic [LINES-1:0] inv_mask
);

  // R7
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    violation && !restart |=> violation);

  // R8
  viol_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !violation);

  // R5
  early_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && snp_earlier |=> inv_mask[$past(snp_idx)]);

  // R6
  late_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid && !snp_earlier && !commit && !restart |=> inv_mask == '0);

  // R6
  late_noviol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !violation && !(snp_valid && snp_earlier) |=> !violation);

  // R5
  idle_inv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !snp_valid && !commit && !restart |=> inv_mask == '0);

endmodule

bind spec_tag_tracker spec_tag_tracker_chk #(.LINES(LINES), .WORDS(WORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .snp_valid(snp_valid), .snp_idx(snp_idx),
  .snp_earlier(snp_earlier), .commit(commit), .restart(restart),
  .violation(violation), .inv_mask(inv_mask)
);

// File: tb/spec_tag_tracker_bench.sv
`timescale 1ns/1ps
module spec_tag_tracker_bench;
  localparam int LINES = 16;
  localparam int WORDS = 4;
  localparam int IW = $clog2(LINES);
  localparam int WW = $clog2(WORDS);

  logic clk = 0, rst_n = 0;
  logic ld_valid = 0, ld_miss = 0, st_valid = 0, snp_valid = 0, snp_earlier = 0;
  logic commit = 0, restart = 0;
  logic [IW-1:0] ld_idx = 0, st_idx = 0, snp_idx = 0;
  logic [WW-1:0] ld_word = 0, st_word = 0;
  logic [WORDS-1:0] snp_mask = 0;
  logic violation;
  logic [LINES-1:0] inv_mask;

  int compared = 0, mismatched = 0, cyc = 0;
  string tag = "R1";

  bit m_rd [LINES][WORDS];
  bit m_wr [LINES][WORDS];
  bit m_mod [LINES];
  bit m_stale [LINES];
  bit m_viol;
  logic [LINES-1:0] exp_inv;

  spec_tag_tracker #(.LINES(LINES), .WORDS(WORDS)) u_spec_tag_tracker (.*);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      mismatched++;
      $display("FAIL R5 watchdog actual=%0d cycles expected<=150000", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic clear_model(bit keep_stale);
    for (int l = 0; l < LINES; l++) begin
      m_mod[l] = 0;
      if (!keep_stale) m_stale[l] = 0;
      for (int w = 0; w < WORDS; w++) begin m_rd[l][w] = 0; m_wr[l][w] = 0; end
    end
  endtask

  task automatic idle();
    ld_valid = 0; st_valid = 0; snp_valid = 0; commit = 0; restart = 0; ld_miss = 0;
  endtask

  task automatic compare();
    compared++;
    if (violation !== m_viol) begin
      mismatched++;
      $display("FAIL %s violation actual=%0b expected=%0b", tag, violation, m_viol);
    end
    compared++;
    if (inv_mask !== exp_inv) begin
      mismatched++;
      $display("FAIL %s inv_mask actual=%h expected=%h", tag, inv_mask, exp_inv);
    end
  endtask

  task automatic step();
    bit haz = 0;
    exp_inv = '0;
    if (snp_valid && snp_earlier) begin
      exp_inv[snp_idx] = 1;
      for (int w = 0; w < WORDS; w++)
        if (snp_mask[w] && m_rd[snp_idx][w] && !m_wr[snp_idx][w]) haz = 1;
    end
    if (restart) begin
      for (int l = 0; l < LINES; l++) if (m_mod[l]) exp_inv[l] = 1;
      clear_model(1);
      m_viol = 0;
    end else begin
      if (haz) m_viol = 1;
      if (commit) begin
        for (int l = 0; l < LINES; l++) if (m_stale[l]) exp_inv[l] = 1;
        clear_model(0);
      end else begin
        if (ld_valid) begin m_rd[ld_idx][ld_word] = 1; if (ld_miss) m_mod[ld_idx] = 1; end
        if (st_valid) begin m_wr[st_idx][st_word] = 1; m_mod[st_idx] = 1; end
        if (snp_valid && !snp_earlier) m_stale[snp_idx] = 1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    compare();
    idle();
  endtask

  task automatic load(int l, int w, bit miss);
    ld_valid = 1; ld_idx = IW'(l); ld_word = WW'(w); ld_miss = miss;
  endtask
  task automatic store(int l, int w);
    st_valid = 1; st_idx = IW'(l); st_word = WW'(w);
  endtask
  task automatic snoop(int l, int mask, bit earlier);
    snp_valid = 1; snp_idx = IW'(l); snp_mask = WORDS'(mask); snp_earlier = earlier;
  endtask

  initial begin
    clear_model(0);
    m_viol = 0;
    exp_inv = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    tag = "R1"; compare();

    tag = "R2"; load(3, 1, 0); step();
    snoop(3, 4'b0001, 1); step();
    snoop(3, 4'b0010, 1); step();
    tag = "R7"; step(); step(); step();
    tag = "R8"; restart = 1; step();
    tag = "R2"; step();

    tag = "R3"; load(5, 0, 1); step();
    restart = 1; step();
    snoop(5, 4'b0001, 1); step();

    tag = "R4"; load(2, 2, 0); step();
    store(2, 2); step();
    snoop(2, 4'b0100, 1); step();
    restart = 1; step();

    tag = "R6"; load(7, 0, 0); step();
    snoop(7, 4'b1111, 0); step();
    step();
    tag = "R9"; commit = 1; step();
    snoop(7, 4'b0001, 1); step();
    load(1, 0, 1); step();
    snoop(8, 4'b0001, 0); commit = 1; step();
    snoop(1, 4'b0001, 1); step();

    tag = "R8"; snoop(9, 4'b0001, 0); step();
    load(6, 3, 1); step();
    restart = 1; step();
    commit = 1; step();

    tag = "R10"; store(10, 1); step();
    snoop(11, 4'b0010, 0); step();
    commit = 1; restart = 1; load(4, 3, 0); step();
    snoop(4, 4'b1000, 1); step();
    commit = 1; step();
    snoop(12, 4'b0001, 0); commit = 1; step();
    commit = 1; step();

    tag = "R5";
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom_range(0, 99);
      if ($urandom_range(0, 2) == 0) load($urandom_range(0, LINES-1), $urandom_range(0, WORDS-1), $urandom_range(0, 1));
      if ($urandom_range(0, 3) == 0) store($urandom_range(0, LINES-1), $urandom_range(0, WORDS-1));
      if ($urandom_range(0, 2) == 0) snoop($urandom_range(0, LINES-1), $urandom_range(1, 15), $urandom_range(0, 1));
      if (r < 3) restart = 1;
      if (r >= 3 && r < 6) commit = 1;
      step();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule